// File: doc/BRIEF.md
# SPI word-to-byte FIFO pair

This block sits between a 32-bit register port and a byte-serial SPI shift engine. Software pushes transmit data as whole 32-bit words into one write port. The block breaks each word into bytes, queues them, and hands them to the engine one byte per pop. In the other direction, the engine pushes received bytes one at a time. A software read collects up to four of the oldest bytes and packs them into a 32-bit word, which appears on a registered read port.

Each direction holds at most 32 bytes, which is the largest chunk moved without DMA. A transmit chunk length tells the block how many bytes of the final word of a chunk are real. A received tail shorter than a word is returned zero-padded. Byte order inside a word is chosen separately for each direction. A synchronous soft reset empties both queues, rewinds every pointer and clears the sticky error flags.

Top module: `spi_word_fifo`

## Requirements
- R1: After `rst_n` low, or one cycle after `soft_rst` high, both byte counts are 0. Both empty flags are 1, both sticky flags are 0, and `rx_rd_data` is 0.
- R2: Transmit byte lanes: the lane taken first goes out first. With `tx_swap`=0, lane k is bits [8k+7:8k], so bits [7:0] leave first. With `tx_swap`=1, lane k is bits [8(3-k)+7:8(3-k)], so bits [31:24] leave first. `tx_swap` is sampled in the write cycle.
- R3: `chunk_len` in 1..32 sets the chunk size in bytes; 0 means every write is a whole word. Each accepted write takes min(4, bytes left in the chunk) lanes, starting at lane 0, and discards the other lanes. When a chunk is complete, the next write starts a new chunk.
- R4: A write whose byte count exceeds the free space is dropped entirely and leaves `tx_count` unchanged. It sets `tx_ovf`, which stays set until a soft reset.
- R5: `tx_byte_valid` is 1 exactly when `tx_count` > 0, and `tx_byte` shows the oldest byte. Each cycle with `tx_pop` removes one byte. A pop while the queue is empty has no effect.
- R6: A read of a non-empty receive queue takes min(4, `rx_count`) of the oldest bytes. The oldest byte goes in lane 0, with lanes mapped by `rx_swap` as in R2, and unused lanes are 0. The word appears on `rx_rd_data` one cycle after `rx_rd_en` and is held until the next read.
- R7: A read of an empty receive queue loads 0 into `rx_rd_data` and sets `rx_udf`, which stays set until a soft reset.
- R8: A byte pushed while `rx_count` is 32 is dropped, and the count stays unchanged.
- R9: `tx_count` and `rx_count` give the number of queued bytes. The full flag is set at 32 and the empty flag at 0.
- R10: A write and a pop in the same cycle both take effect. The free-space test for the write uses the count before the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of both queues and sticky flags |
| tx_swap | input | 1 | Transmit lane order select (R2) |
| rx_swap | input | 1 | Receive lane order select (R6) |
| chunk_len | input | 6 | Transmit chunk size in bytes, 0 = whole words |
| tx_wr_en | input | 1 | Transmit word write strobe |
| tx_wr_data | input | 32 | Transmit word |
| tx_pop | input | 1 | Engine takes the current transmit byte |
| tx_byte_valid | output | 1 | A transmit byte is available |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_count | output | 6 | Queued transmit bytes |
| tx_full | output | 1 | Transmit queue holds 32 bytes |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_ovf | output | 1 | Sticky: a transmit write was dropped |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_push_byte | input | 8 | Received byte |
| rx_rd_en | input | 1 | Receive word read strobe |
| rx_rd_data | output | 32 | Last word read (registered) |
| rx_count | output | 6 | Queued receive bytes |
| rx_full | output | 1 | Receive queue holds 32 bytes |
| rx_empty | output | 1 | Receive queue is empty |
| rx_udf | output | 1 | Sticky: a read found the queue empty |

## Verification
The assertions assume that `chunk_len` is at most 32 and does not change while a chunk is partly written. Under that assumption, the count of bytes already written in a chunk is always below the chunk length. The assertions also assume that `soft_rst` and `rst_n` are the only ways to clear the sticky flags. The stimulus therefore changes `chunk_len` only right after a soft reset or at a chunk boundary. The swap selects, strobes and data are left free to vary every cycle, and pushes into a full queue and reads of an empty queue are driven deliberately.

// File: rtl/spi_wf_pkg.sv
package spi_wf_pkg;
    localparam int BPW = 4;                 // bytes per register word
    localparam int WW  = 8 * BPW;           // register word width
    localparam int TKW = $clog2(BPW + 1);   // width of a per-access byte count

    // bit-lane index of the k-th byte in queue order
    function automatic int lane_pos(input int k, input logic swap);
        return swap ? (BPW - 1 - k) : k;
    endfunction
endpackage

// File: rtl/spi_wf_tx.sv
module spi_wf_tx
    import spi_wf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          swap,
    input  logic [CW-1:0] chunk_len,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_data,
    input  logic          pop,
    output logic          byte_valid,
    output logic [7:0]    byte_out,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          ovf
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wptr;
        logic [AW-1:0]         rptr;
        logic [CW-1:0]         cnt;
        logic [CW-1:0]         sent;
        logic                  ovf;
    } tx_state_t;

    tx_state_t      s_q, s_d;
    logic [CW-1:0]  rem;
    logic [TKW-1:0] take;
    logic           pop_ok;
    logic           wr_ok;

    always_comb begin
        s_d    = s_q;
        rem    = chunk_len - s_q.sent;
        take   = (chunk_len == '0 || rem >= CW'(BPW)) ? TKW'(BPW) : TKW'(rem);
        pop_ok = pop && (s_q.cnt != '0);
        wr_ok  = wr_en && (CW'(take) <= (CW'(DEPTH) - s_q.cnt));
        if (pop_ok) s_d.rptr = s_q.rptr + AW'(1);
        if (wr_en && !wr_ok) s_d.ovf = 1'b1;
        if (wr_ok) begin
            for (int k = 0; k < BPW; k++) begin
                if (TKW'(k) < take)
                    s_d.mem[s_q.wptr + AW'(k)] = wr_data[8*lane_pos(k, swap) +: 8];
            end
            s_d.wptr = s_q.wptr + AW'(take);
            s_d.sent = (chunk_len == '0 || (s_q.sent + CW'(take)) == chunk_len)
                       ? '0 : s_q.sent + CW'(take);
        end
        s_d.cnt = s_q.cnt + (wr_ok ? CW'(take) : '0) - (pop_ok ? CW'(1) : '0);
        if (flush) begin
            s_d.wptr = '0;
            s_d.rptr = '0;
            s_d.cnt  = '0;
            s_d.sent = '0;
            s_d.ovf  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign byte_valid = (s_q.cnt != '0);
    assign byte_out   = s_q.mem[s_q.rptr];
    assign count      = s_q.cnt;
    assign full       = (s_q.cnt == CW'(DEPTH));
    assign empty      = (s_q.cnt == '0);
    assign ovf        = s_q.ovf;

    p_flush_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !ovf));
    p_pop_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !wr_en && !flush && count != '0) |=> (count == $past(count) - CW'(1)));
    p_ovf_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(wr_en && !flush));
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !pop && !flush) |=> $stable(count));
endmodule

// File: rtl/spi_wf_rx.sv
module spi_wf_rx
    import spi_wf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          swap,
    input  logic          push,
    input  logic [7:0]    push_byte,
    input  logic          rd_en,
    output logic [WW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          udf
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wptr;
        logic [AW-1:0]         rptr;
        logic [CW-1:0]         cnt;
        logic [WW-1:0]         rdata;
        logic                  udf;
    } rx_state_t;

    rx_state_t      s_q, s_d;
    logic [TKW-1:0] take;
    logic           push_ok;

    always_comb begin
        s_d     = s_q;
        push_ok = push && (s_q.cnt != CW'(DEPTH));
        take    = (s_q.cnt >= CW'(BPW)) ? TKW'(BPW) : TKW'(s_q.cnt);
        if (rd_en) begin
            s_d.rdata = '0;
            if (s_q.cnt == '0) begin
                s_d.udf = 1'b1;
            end else begin
                for (int k = 0; k < BPW; k++) begin
                    if (TKW'(k) < take)
                        s_d.rdata[8*lane_pos(k, swap) +: 8] = s_q.mem[s_q.rptr + AW'(k)];
                end
                s_d.rptr = s_q.rptr + AW'(take);
            end
        end
        if (push_ok) begin
            s_d.mem[s_q.wptr] = push_byte;
            s_d.wptr          = s_q.wptr + AW'(1);
        end
        s_d.cnt = s_q.cnt + (push_ok ? CW'(1) : '0) - (rd_en ? CW'(take) : '0);
        if (flush) begin
            s_d.wptr  = '0;
            s_d.rptr  = '0;
            s_d.cnt   = '0;
            s_d.rdata = '0;
            s_d.udf   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = s_q.rdata;
    assign count   = s_q.cnt;
    assign full    = (s_q.cnt == CW'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign udf     = s_q.udf;

    p_flush_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && rd_data == '0 && !udf));
    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !flush) |=> (rd_data == '0 && udf));
    p_full_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !rd_en && !flush) |=> $stable(count));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !flush) |=> $stable(rd_data));
endmodule

// File: rtl/spi_word_fifo.sv
module spi_word_fifo
    import spi_wf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          tx_swap,
    input  logic          rx_swap,
    input  logic [CW-1:0] chunk_len,
    input  logic          tx_wr_en,
    input  logic [WW-1:0] tx_wr_data,
    input  logic          tx_pop,
    output logic          tx_byte_valid,
    output logic [7:0]    tx_byte,
    output logic [CW-1:0] tx_count,
    output logic          tx_full,
    output logic          tx_empty,
    output logic          tx_ovf,
    input  logic          rx_push,
    input  logic [7:0]    rx_push_byte,
    input  logic          rx_rd_en,
    output logic [WW-1:0] rx_rd_data,
    output logic [CW-1:0] rx_count,
    output logic          rx_full,
    output logic          rx_empty,
    output logic          rx_udf
);
    spi_wf_tx #(.DEPTH(DEPTH)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (soft_rst),
        .swap       (tx_swap),
        .chunk_len  (chunk_len),
        .wr_en      (tx_wr_en),
        .wr_data    (tx_wr_data),
        .pop        (tx_pop),
        .byte_valid (tx_byte_valid),
        .byte_out   (tx_byte),
        .count      (tx_count),
        .full       (tx_full),
        .empty      (tx_empty),
        .ovf        (tx_ovf)
    );

    spi_wf_rx #(.DEPTH(DEPTH)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (soft_rst),
        .swap      (rx_swap),
        .push      (rx_push),
        .push_byte (rx_push_byte),
        .rd_en     (rx_rd_en),
        .rd_data   (rx_rd_data),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty),
        .udf       (rx_udf)
    );

    p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));
endmodule

// File: tb/spi_word_fifo_tb.sv
`timescale 1ns/1ps
module spi_word_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n, soft_rst, tx_swap, rx_swap;
    logic [5:0]  chunk_len;
    logic        tx_wr_en, tx_pop, rx_push, rx_rd_en;
    logic [31:0] tx_wr_data;
    logic [7:0]  rx_push_byte;
    logic        tx_byte_valid, tx_full, tx_empty, tx_ovf;
    logic [7:0]  tx_byte;
    logic [5:0]  tx_count, rx_count;
    logic [31:0] rx_rd_data;
    logic        rx_full, rx_empty, rx_udf;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #4 clk = ~clk;   // 125 MHz

    spi_word_fifo u_dut (.*);

    // ---------------- behavioural reference ----------------
    logic [7:0]  m_tx[$];
    logic [7:0]  m_rx[$];
    int          m_sent;
    bit          m_ovf, m_udf;
    logic [31:0] m_rdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || soft_rst) begin
            m_tx.delete(); m_rx.delete();
            m_sent = 0; m_ovf = 0; m_udf = 0; m_rdata = 0;
        end else begin
            int  rem, take, free_b, rtake;
            bit  pop_ok, rx_was_full;
            rem    = int'(chunk_len) - m_sent;
            take   = (chunk_len == 0 || rem >= 4) ? 4 : rem;
            pop_ok = tx_pop && (m_tx.size() > 0);
            free_b = 32 - m_tx.size();
            if (pop_ok) void'(m_tx.pop_front());
            if (tx_wr_en) begin
                if (take <= free_b) begin
                    for (int k = 0; k < take; k++)
                        m_tx.push_back(tx_swap ? tx_wr_data[8*(3-k) +: 8] : tx_wr_data[8*k +: 8]);
                    m_sent = (chunk_len == 0 || m_sent + take == int'(chunk_len)) ? 0 : m_sent + take;
                end else m_ovf = 1;
            end
            rx_was_full = (m_rx.size() == 32);
            if (rx_rd_en) begin
                m_rdata = 0;
                if (m_rx.size() == 0) m_udf = 1;
                else begin
                    rtake = (m_rx.size() >= 4) ? 4 : m_rx.size();
                    for (int k = 0; k < rtake; k++) begin
                        logic [7:0] b;
                        b = m_rx.pop_front();
                        if (rx_swap) m_rdata[8*(3-k) +: 8] = b;
                        else         m_rdata[8*k +: 8] = b;
                    end
                end
            end
            if (rx_push && !rx_was_full) m_rx.push_back(rx_push_byte);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        check("R9 tx_count", 32'(tx_count), 32'(m_tx.size()));
        check("R9 tx_full", 32'(tx_full), 32'(m_tx.size() == 32));
        check("R9 tx_empty", 32'(tx_empty), 32'(m_tx.size() == 0));
        check("R5 tx_byte_valid", 32'(tx_byte_valid), 32'(m_tx.size() != 0));
        if (m_tx.size() != 0) check("R2 tx_byte", 32'(tx_byte), 32'(m_tx[0]));
        check("R4 tx_ovf", 32'(tx_ovf), 32'(m_ovf));
        check("R8 rx_count", 32'(rx_count), 32'(m_rx.size()));
        check("R9 rx_full", 32'(rx_full), 32'(m_rx.size() == 32));
        check("R6 rx_rd_data", rx_rd_data, m_rdata);
        check("R7 rx_udf", 32'(rx_udf), 32'(m_udf));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
        tx_wr_en = 0; tx_pop = 0; rx_push = 0; rx_rd_en = 0; soft_rst = 0;
    endtask

    task automatic wr(input logic [31:0] d);
        tx_wr_en = 1; tx_wr_data = d; step();
    endtask

    task automatic push(input logic [7:0] b);
        rx_push = 1; rx_push_byte = b; step();
    endtask

    task automatic flush();
        soft_rst = 1; step();
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; soft_rst = 0; tx_swap = 0; rx_swap = 0; chunk_len = 0;
        tx_wr_en = 0; tx_pop = 0; rx_push = 0; rx_rd_en = 0;
        tx_wr_data = 0; rx_push_byte = 0;
        step(); step();
        rst_n = 1;
        step();
        // R1 reset state
        check("R1 tx_count", 32'(tx_count), 0);
        check("R1 rx_count", 32'(rx_count), 0);
        check("R1 tx_empty", 32'(tx_empty), 1);
        check("R1 rx_empty", 32'(rx_empty), 1);
        check("R1 rx_rd_data", rx_rd_data, 0);
        check("R1 flags", {30'd0, tx_ovf, rx_udf}, 0);

        // R2 lane order, little end first
        wr(32'h44332211);
        check("R2 lane0 first", 32'(tx_byte), 32'h11);
        tx_pop = 1; step(); check("R2 lane1", 32'(tx_byte), 32'h22);
        tx_pop = 1; step(); check("R2 lane2", 32'(tx_byte), 32'h33);
        tx_pop = 1; step(); check("R2 lane3", 32'(tx_byte), 32'h44);
        tx_pop = 1; step(); check("R5 drained", 32'(tx_byte_valid), 0);
        tx_pop = 1; step(); check("R5 pop on empty", 32'(tx_count), 0);
        // R2 swapped order
        tx_swap = 1; wr(32'h44332211); tx_swap = 0;
        check("R2 swapped first", 32'(tx_byte), 32'h44);
        flush();

        // R3 partial final word
        chunk_len = 6;
        wr(32'hAABBCCDD);
        wr(32'h11223344);
        check("R3 chunk of 6", 32'(tx_count), 6);
        wr(32'h55667788);
        check("R3 next chunk whole", 32'(tx_count), 10);
        for (int i = 0; i < 4; i++) begin tx_pop = 1; step(); end
        check("R3 tail lane0", 32'(tx_byte), 32'h44);
        flush();
        chunk_len = 0;

        // R9 full, R4 overflow
        for (int i = 0; i < 8; i++) wr(32'h01020304 + 32'(i));
        check("R9 tx_full", 32'(tx_full), 1);
        wr(32'hDEADBEEF);
        check("R4 overflow sticky", 32'(tx_ovf), 1);
        check("R4 count kept", 32'(tx_count), 32);
        flush();
        check("R1 ovf cleared", 32'(tx_ovf), 0);

        // R10 write with pop
        for (int i = 0; i < 7; i++) wr(32'hA0A0A0A0 + 32'(i));
        tx_pop = 1; wr(32'h12345678);
        check("R10 write and pop", 32'(tx_count), 31);
        tx_pop = 1; wr(32'h12345678);
        check("R10 space before pop", 32'(tx_count), 30);
        flush();

        // R6 receive packing, R7 underflow
        for (int i = 1; i <= 6; i++) push(8'(i));
        rx_rd_en = 1; step();
        check("R6 full word", rx_rd_data, 32'h04030201);
        rx_rd_en = 1; step();
        check("R6 padded tail", rx_rd_data, 32'h00000605);
        step();
        check("R6 held", rx_rd_data, 32'h00000605);
        rx_rd_en = 1; step();
        check("R7 empty read zero", rx_rd_data, 0);
        check("R7 underflow sticky", 32'(rx_udf), 1);
        rx_swap = 1;
        push(8'hA1); push(8'hA2); push(8'hA3);
        rx_rd_en = 1; step();
        check("R6 swapped tail", rx_rd_data, 32'hA1A2A300);
        rx_swap = 0;
        for (int i = 0; i < 33; i++) push(8'(i));
        check("R8 push when full", 32'(rx_count), 32);
        flush();
        check("R1 udf cleared", 32'(rx_udf), 0);

        // mixed traffic against the reference
        chunk_len = 13;
        for (int i = 0; i < 4000; i++) begin
            tx_swap      = 1'($urandom);
            rx_swap      = 1'($urandom);
            tx_wr_en     = ($urandom % 10) < 4;
            tx_wr_data   = $urandom;
            tx_pop       = ($urandom % 2) == 0;
            rx_push      = ($urandom % 2) == 0;
            rx_push_byte = 8'($urandom);
            rx_rd_en     = ($urandom % 4) == 0;
            soft_rst     = ($urandom % 100) == 0;
            step();
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule